// File: doc/BRIEF.md
# Bridge Overcurrent Hiccup Supervisor

This block sits between the overcurrent comparators of a full H-bridge and the bridge control decoder. It watches two active-high comparator flags, one for the high-side switches and one for the low-side switches. A flag must stay high for a programmable number of consecutive clock cycles before it counts as a real short. Anything shorter is treated as switching noise and has no effect.

When a short is confirmed, the block forces the bridge off and raises a fault flag. It then holds the bridge off for a fixed number of cycles. After that off-time it releases both the bridge and the fault flag, and the bridge follows its normal commands again. If the short is still there, the same qualification sends the block back into the off-time, so a persistent short gives a repeating hiccup pattern. If the short has cleared, the block returns to normal running.

A low level on the active-low sleep input returns the block to running at once, with the fault cleared and the counters stopped. Both times are set in clock cycles, so a simulation can use short values.

Top module: `ocp_hiccup_guard`

## Requirements
- R1: A high level on either `oc_hi` or `oc_lo` is a short. It is confirmed only after the synchronised flag has been sampled high on DEGLITCH_CYC consecutive rising edges. `bridge_off` and `oc_fault` go to 1 after the SYNC_STAGES+DEGLITCH_CYC-th rising edge, counting from the first edge that sees the raw flag high.
- R2: A flag pulse that lasts fewer than DEGLITCH_CYC cycles never sets `bridge_off` or `oc_fault`.
- R3: If the flag drops before confirmation, the qualification count restarts from zero. Two sub-threshold pulses separated by one low cycle do not add up to a fault.
- R4: Once a short is confirmed, `bridge_off` and `oc_fault` both stay at 1 for exactly RETRY_CYC rising edges, whatever the flags do.
- R5: At the end of the off-time, `bridge_off` and `oc_fault` both return to 0 for the retry attempt.
- R6: If the flag is still high during the retry attempt, DEGLITCH_CYC consecutive high samples during the attempt send the block back into the off-time with both outputs at 1.
- R7: If the flag is low when the retry attempt starts, the block returns to normal running and both outputs stay 0.
- R8: While `sleep_n` is 0, both outputs are 0 from the next rising edge on and the flags are ignored. After `sleep_n` returns to 1, qualification starts from zero.
- R9: After reset, `bridge_off` and `oc_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low sleep; low returns the block to running (synchronous) |
| oc_hi | input | 1 | High-side overcurrent comparator flag, active high, asynchronous |
| oc_lo | input | 1 | Low-side overcurrent comparator flag, active high, asynchronous |
| bridge_off | output | 1 | 1 forces every bridge switch off |
| oc_fault | output | 1 | 1 while a confirmed short is in its off-time |

## Verification
A raw flag edge reaches the outputs after SYNC_STAGES+DEGLITCH_CYC rising edges. The outputs are then released exactly RETRY_CYC edges after they were set. A persistent short during a retry re-trips after DEGLITCH_CYC further edges, and a low on `sleep_n` clears the outputs after one edge.

The bench drives inputs on falling edges and advances a counted number of rising edges. It then samples on the next falling edge. Each timing check looks at the output both one edge before and at the edge where the change is due, so an early or late change is caught. The ignore cases are checked on every cycle of a window long enough to cover a full qualification.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_QUAL  = 2'd1,
      ST_OFF   = 2'd2,
      ST_RETRY = 2'd3
   } guard_state_t;

   function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/ocp_flag_cond.sv
module ocp_flag_cond #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NUM_FLAGS   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] flags_raw,
   output logic                 flag_any
);

   initial begin
      if (SYNC_STAGES > 4)
         $error("ocp_flag_cond: SYNC_STAGES must be 0..4");
      if (NUM_FLAGS < 1)
         $error("ocp_flag_cond: NUM_FLAGS must be at least 1");
   end

   logic [NUM_FLAGS-1:0] flags_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign flags_s = flags_raw;
      end else begin : g_sync
         logic [NUM_FLAGS-1:0] chain [SYNC_STAGES];
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  chain[i] <= '0;
               else if (i == 0)
                  chain[i] <= flags_raw;
               else
                  chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
         end
         assign flags_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign flag_any = |flags_s;

endmodule

// File: rtl/ocp_cycle_counter.sv
module ocp_cycle_counter #(
   parameter int unsigned LIMIT = 16,
   parameter int unsigned WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [WIDTH-1:0] count
);

   initial begin
      if ((2**WIDTH) < LIMIT)
         $error("ocp_cycle_counter: WIDTH too small for LIMIT");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc)
         count <= count + 1'b1;
   end

   AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(count) < LIMIT) else $error("counter beyond limit"); // R4

endmodule

// File: rtl/ocp_guard_fsm.sv
module ocp_guard_fsm
   import ocp_hiccup_pkg::*;
#(
   parameter int unsigned DEGLITCH_CYC = 375,
   parameter int unsigned RETRY_CYC    = 150000,
   parameter int unsigned CNT_W        = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_n,
   input  logic             oc_s,
   input  logic [CNT_W-1:0] count,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output guard_state_t     state
);

   localparam logic [CNT_W-1:0] DEG_LAST   = CNT_W'(DEGLITCH_CYC - 1);
   localparam logic [CNT_W-1:0] RETRY_LAST = CNT_W'(RETRY_CYC - 1);

   guard_state_t nxt;

   always_comb begin
      nxt     = state;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      if (!sleep_n) begin
         nxt     = ST_RUN;
         cnt_clr = 1'b1;
      end else begin
         unique case (state)
            ST_RUN: begin
               if (oc_s) begin
                  nxt     = ST_QUAL;
                  cnt_inc = 1'b1;
               end else begin
                  cnt_clr = 1'b1;
               end
            end
            ST_QUAL, ST_RETRY: begin
               if (!oc_s) begin
                  nxt     = ST_RUN;
                  cnt_clr = 1'b1;
               end else if (count == DEG_LAST) begin
                  nxt     = ST_OFF;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_OFF: begin
               if (count == RETRY_LAST) begin
                  nxt     = ST_RETRY;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            default: begin
               nxt     = ST_RUN;
               cnt_clr = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_RUN;
      else
         state <= nxt;
   end

   AST_TRIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_OFF) ##1 (state == ST_OFF) |-> $past(oc_s)) else $error("trip without flag"); // R1
   AST_DROP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_QUAL && !oc_s && sleep_n) |=> (state == ST_RUN && count == '0)) else $error("no restart"); // R3
   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF && count != RETRY_LAST && sleep_n) |=> state == ST_OFF) else $error("off-time cut short"); // R4
   AST_OFF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF && count == RETRY_LAST && sleep_n) |=> state == ST_RETRY) else $error("no retry"); // R5
   AST_RETRY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RETRY && !oc_s && sleep_n) |=> state == ST_RUN) else $error("retry not released"); // R7
   AST_SLEEP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |=> (state == ST_RUN && count == '0)) else $error("sleep not honoured"); // R8

endmodule

// File: rtl/ocp_hiccup_guard.sv
module ocp_hiccup_guard
   import ocp_hiccup_pkg::*;
#(
   parameter int unsigned DEGLITCH_CYC = 375,
   parameter int unsigned RETRY_CYC    = 150000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_n,
   input  logic oc_hi,
   input  logic oc_lo,
   output logic bridge_off,
   output logic oc_fault
);

   localparam int unsigned CNT_LIMIT = larger_of(DEGLITCH_CYC, RETRY_CYC);
   localparam int unsigned CNT_W     = bits_for(CNT_LIMIT);

   initial begin
      if (DEGLITCH_CYC < 2)
         $error("ocp_hiccup_guard: DEGLITCH_CYC must be at least 2");
      if (RETRY_CYC < 1)
         $error("ocp_hiccup_guard: RETRY_CYC must be at least 1");
   end

   logic             oc_s;
   logic             cnt_clr;
   logic             cnt_inc;
   logic [CNT_W-1:0] count;
   guard_state_t     state;

   ocp_flag_cond #(
      .SYNC_STAGES (SYNC_STAGES),
      .NUM_FLAGS   (2)
   ) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_raw ({oc_hi, oc_lo}),
      .flag_any  (oc_s)
   );

   ocp_cycle_counter #(
      .LIMIT (CNT_LIMIT),
      .WIDTH (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .count (count)
   );

   ocp_guard_fsm #(
      .DEGLITCH_CYC (DEGLITCH_CYC),
      .RETRY_CYC    (RETRY_CYC),
      .CNT_W        (CNT_W)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep_n (sleep_n),
      .oc_s    (oc_s),
      .count   (count),
      .cnt_clr (cnt_clr),
      .cnt_inc (cnt_inc),
      .state   (state)
   );

   assign bridge_off = (state == ST_OFF);
   assign oc_fault   = (state == ST_OFF);

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !bridge_off) else $error("active after reset"); // R9

endmodule

// File: tb/ocp_hiccup_guard_test.sv
`timescale 1ns/1ps
module ocp_hiccup_guard_test;

   localparam int DEG   = 4;
   localparam int RETRY = 20;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_n = 1'b1;
   logic oc_hi = 1'b0;
   logic oc_lo = 1'b0;
   logic bridge_off;
   logic oc_fault;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   ocp_hiccup_guard #(
      .DEGLITCH_CYC (DEG),
      .RETRY_CYC    (RETRY),
      .SYNC_STAGES  (SYNC)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_n    (sleep_n),
      .oc_hi      (oc_hi),
      .oc_lo      (oc_lo),
      .bridge_off (bridge_off),
      .oc_fault   (oc_fault)
   );

   task automatic adv(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic exp_off, input logic exp_flt);
      checks++;
      if (bridge_off !== exp_off || oc_fault !== exp_flt) begin
         fails++;
         $display("FAIL %s: bridge_off/oc_fault = %b/%b, expected %b/%b",
                  req, bridge_off, oc_fault, exp_off, exp_flt);
      end
   endtask

   task automatic t_reset();
      check("R9", 1'b0, 1'b0);
   endtask

   task automatic t_confirm();
      oc_hi = 1'b1;
      adv(SYNC + DEG - 1);
      check("R1", 1'b0, 1'b0);
      adv(1);
      check("R1", 1'b1, 1'b1);
      oc_hi = 1'b0;
      adv(RETRY - 2);
      check("R4", 1'b1, 1'b1);
      adv(1);
      check("R4", 1'b1, 1'b1);
      adv(1);
      check("R5", 1'b0, 1'b0);
      adv(30);
      check("R7", 1'b0, 1'b0);
   endtask

   task automatic t_glitch();
      oc_lo = 1'b1;
      adv(DEG - 1);
      oc_lo = 1'b0;
      for (int i = 0; i < 12; i++) begin
         adv(1);
         check("R2", 1'b0, 1'b0);
      end
   endtask

   task automatic t_restart();
      oc_hi = 1'b1;
      adv(DEG - 1);
      oc_hi = 1'b0;
      adv(1);
      oc_hi = 1'b1;
      adv(DEG - 1);
      oc_hi = 1'b0;
      for (int i = 0; i < 10; i++) begin
         adv(1);
         check("R3", 1'b0, 1'b0);
      end
   endtask

   task automatic t_repeat();
      oc_lo = 1'b1;
      adv(SYNC + DEG);
      check("R1", 1'b1, 1'b1);
      adv(RETRY);
      check("R5", 1'b0, 1'b0);
      adv(DEG - 1);
      check("R6", 1'b0, 1'b0);
      adv(1);
      check("R6", 1'b1, 1'b1);
      oc_lo = 1'b0;
      adv(RETRY);
      check("R5", 1'b0, 1'b0);
      adv(40);
      check("R7", 1'b0, 1'b0);
   endtask

   task automatic t_sleep();
      oc_hi = 1'b1;
      adv(SYNC + DEG);
      check("R1", 1'b1, 1'b1);
      sleep_n = 1'b0;
      adv(1);
      check("R8", 1'b0, 1'b0);
      for (int i = 0; i < 12; i++) begin
         adv(1);
         check("R8", 1'b0, 1'b0);
      end
      sleep_n = 1'b1;
      adv(DEG - 1);
      check("R8", 1'b0, 1'b0);
      adv(1);
      check("R8", 1'b1, 1'b1);
      sleep_n = 1'b0;
      oc_hi = 1'b0;
      adv(3);
      sleep_n = 1'b1;
      adv(8);
      check("R8", 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      adv(2);
      t_reset();
      t_confirm();
      t_glitch();
      t_restart();
      t_repeat();
      t_sleep();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, actual timeout, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule